// File: doc/BRIEF.md
# Cache-Block Zero and Probe Sequencer

This block carries out the memory side of a cache-block management operation once the decode and permission logic has settled which operation is to run. It takes an operation kind and a base address. It rounds the address down to the start of its cache block, then drives a simple request/response memory port until the operation finishes. The port's response models both address translation and the memory access, and either can fault.

A zero operation stores a 0x00 byte at every byte of the block. It goes one byte at a time in ascending address order and stops at the first fault. A clean, flush or invalidate operation is a permission probe only. It issues one single-byte read at the block start and does nothing to any cache. When the operation ends, the block pulses done for one cycle with a success flag. On failure it also gives the trap logic a store/AMO exception code and the block start address. A fault on the probe read is always reported as a store/AMO fault, never as a load fault.

The block size is a parameter. It must be a power of two of at least 2 bytes, and any other value stops elaboration.

Top module: `cbo_seq`

## Requirements
- R1: Every memory request made for an operation addresses a byte inside the cache block that contains `op_addr`. The block start is `op_addr` with its low log2(BLK_BYTES) bits cleared.
- R2: With `op_kind` = 0 (zero), the block issues write requests (`mem_we`=1, `mem_wdata`=0x00) at block start + 0, +1, ... in ascending order, one for each accepted response. It ends with `done_ok`=1 after BLK_BYTES successful writes.
- R3: A fault response during a zero operation ends the operation in the cycle after that response, with `done_ok`=0. No later byte is requested: bytes below the faulting byte are zero and the rest of the block keeps its contents.
- R4: On failure, `exc_addr` equals the block start address, whatever the byte or operation that faulted.
- R5: With `op_kind` = 1 (clean), 2 (flush) or 3 (invalidate), the block issues exactly one read request (`mem_we`=0) at the block start and no writes. It ends with `done_ok`=1 if that read succeeds.
- R6: A fault response with `mem_page`=1 (page fault) gives `exc_code`=15, and with `mem_page`=0 (access fault) gives `exc_code`=7. This holds for both reads and writes. On success, `exc_code` and `exc_addr` are 0 during the done cycle.
- R7: An operation is accepted only while `busy`=0. `busy` rises in the cycle after acceptance and stays high through the single cycle in which `done` is high. An `op_valid` seen while busy is ignored, and no memory request is made while idle.
- R8: A pending request keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_rsp`. Each response carries exactly one of `mem_ok` and `mem_fault`.
- R9: During and right after reset, `busy`, `done` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Start an operation (taken when idle) |
| op_kind | input | 2 | 0 zero, 1 clean, 2 flush, 3 invalidate |
| op_addr | input | AW | Base address of the operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Operation succeeded (valid with done) |
| exc_code | output | 4 | Exception code on failure, else 0 |
| exc_addr | output | AW | Block start address on failure, else 0 |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | 8 | Write data (always zero) |
| mem_rsp | input | 1 | Response for the pending request |
| mem_ok | input | 1 | Response: access succeeded |
| mem_fault | input | 1 | Response: translation or access fault |
| mem_page | input | 1 | With mem_fault: 1 page fault, 0 access fault |

## Verification
The bench builds the block with a 12-bit address and 8-byte blocks. At that size it can try every operation kind with every byte offset inside the block. It uses three block positions, including the first and the last block of the address space, and response latencies of 0 to 2 cycles. For zero operations it places a page fault or an access fault on each of the eight bytes in turn. This covers a fault on the first byte, one in the middle and one on the last byte. It then checks the exact extent of zeroed memory against a byte-level model kept in the bench.

// File: rtl/cbo_pkg.sv
package cbo_pkg;

  typedef enum logic [1:0] {
    CBO_ZERO  = 2'd0,
    CBO_CLEAN = 2'd1,
    CBO_FLUSH = 2'd2,
    CBO_INVAL = 2'd3
  } cbo_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ZERO  = 2'd1,
    ST_PROBE = 2'd2,
    ST_DONE  = 2'd3
  } cbo_state_e;

  localparam int unsigned EXC_W = 4;
  localparam logic [EXC_W-1:0] EXC_STORE_ACCESS = 4'd7;
  localparam logic [EXC_W-1:0] EXC_STORE_PAGE   = 4'd15;

endpackage

// File: rtl/cbo_rst_sync.sv
module cbo_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/cbo_align.sv
module cbo_align #(
  parameter int unsigned AW        = 32,
  parameter int unsigned BLK_BYTES = 64
) (
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] blk_start
);
  localparam logic [AW-1:0] LOW_MASK = AW'(BLK_BYTES - 1);

  assign blk_start = addr_in & ~LOW_MASK;
endmodule

// File: rtl/cbo_fault_map.sv
module cbo_fault_map
  import cbo_pkg::*;
(
  input  logic             is_page,
  output logic [EXC_W-1:0] code
);
  // Read-probe and write faults both surface as store/AMO faults.
  assign code = is_page ? EXC_STORE_PAGE : EXC_STORE_ACCESS;
endmodule

// File: rtl/cbo_ctrl.sv
module cbo_ctrl
  import cbo_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned BLK_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [1:0]       op_kind,
  input  logic [AW-1:0]    blk_start,
  input  logic [EXC_W-1:0] fault_code,
  output logic             busy,
  output logic             done,
  output logic             done_ok,
  output logic [EXC_W-1:0] exc_code,
  output logic [AW-1:0]    exc_addr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic             mem_rsp,
  input  logic             mem_ok,
  input  logic             mem_fault
);
  localparam int unsigned OFS_W = $clog2(BLK_BYTES);
  localparam logic [OFS_W-1:0] IDX_LAST = OFS_W'(BLK_BYTES - 1);

  cbo_state_e       state_q, state_d;
  logic [AW-1:0]    base_q, base_d;
  logic [OFS_W-1:0] idx_q, idx_d;
  logic             ok_q, ok_d;
  logic [EXC_W-1:0] code_q, code_d;
  logic             rsp_good;
  logic             en_state, en_base, en_idx, en_res;

  assign rsp_good = mem_rsp && mem_ok && !mem_fault;

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    idx_d   = idx_q;
    ok_d    = ok_q;
    code_d  = code_q;
    unique case (state_q)
      ST_IDLE: begin
        if (op_valid) begin
          state_d = (cbo_op_e'(op_kind) == CBO_ZERO) ? ST_ZERO : ST_PROBE;
          base_d  = blk_start;
          idx_d   = '0;
          ok_d    = 1'b0;
          code_d  = '0;
        end
      end
      ST_ZERO: begin
        if (mem_rsp) begin
          if (!rsp_good) begin
            state_d = ST_DONE;
            ok_d    = 1'b0;
            code_d  = fault_code;
          end else if (idx_q == IDX_LAST) begin
            state_d = ST_DONE;
            ok_d    = 1'b1;
          end else begin
            idx_d = idx_q + OFS_W'(1);
          end
        end
      end
      ST_PROBE: begin
        if (mem_rsp) begin
          state_d = ST_DONE;
          ok_d    = rsp_good;
          code_d  = rsp_good ? '0 : fault_code;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Explicit clock enables.
  assign en_state = (state_d != state_q);
  assign en_base  = (state_q == ST_IDLE) && op_valid;
  assign en_idx   = en_base || ((state_q == ST_ZERO) && mem_rsp);
  assign en_res   = en_base || (((state_q == ST_ZERO) || (state_q == ST_PROBE)) && mem_rsp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
      ok_q    <= 1'b0;
      code_q  <= '0;
    end else begin
      if (en_state) state_q <= state_d;
      if (en_base)  base_q  <= base_d;
      if (en_idx)   idx_q   <= idx_d;
      if (en_res) begin
        ok_q   <= ok_d;
        code_q <= code_d;
      end
    end
  end

  // Outputs, all decoded from registers.
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign done_ok   = done && ok_q;
  assign exc_code  = (done && !ok_q) ? code_q : '0;
  assign exc_addr  = (done && !ok_q) ? base_q : '0;
  assign mem_req   = (state_q == ST_ZERO) || (state_q == ST_PROBE);
  assign mem_we    = (state_q == ST_ZERO);
  assign mem_addr  = {base_q[AW-1:OFS_W], idx_q};
  assign mem_wdata = 8'h00;
endmodule

// File: rtl/cbo_seq.sv
module cbo_seq
  import cbo_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned BLK_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [AW-1:0] op_addr,
  output logic          busy,
  output logic          done,
  output logic          done_ok,
  output logic [3:0]    exc_code,
  output logic [AW-1:0] exc_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_rsp,
  input  logic          mem_ok,
  input  logic          mem_fault,
  input  logic          mem_page
);
  if (BLK_BYTES < 2 || (BLK_BYTES & (BLK_BYTES - 1)) != 0) begin : g_bad_blk
    $error("cbo_seq: BLK_BYTES must be a power of two of at least 2");
  end

  logic             rst_n_sync;
  logic [AW-1:0]    blk_start;
  logic [EXC_W-1:0] fault_code;

  cbo_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  cbo_align #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_align (
    .addr_in   (op_addr),
    .blk_start (blk_start)
  );

  cbo_fault_map u_fault_map (
    .is_page (mem_page),
    .code    (fault_code)
  );

  cbo_ctrl #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .blk_start  (blk_start),
    .fault_code (fault_code),
    .busy       (busy),
    .done       (done),
    .done_ok    (done_ok),
    .exc_code   (exc_code),
    .exc_addr   (exc_addr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rsp    (mem_rsp),
    .mem_ok     (mem_ok),
    .mem_fault  (mem_fault)
  );
endmodule

// File: rtl/cbo_seq_chk.sv
module cbo_seq_chk #(
  parameter int unsigned AW        = 32,
  parameter int unsigned BLK_BYTES = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [1:0]    op_kind,
  input logic          busy,
  input logic          done,
  input logic          done_ok,
  input logic [3:0]    exc_code,
  input logic [AW-1:0] exc_addr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rsp,
  input logic          mem_ok,
  input logic          mem_fault,
  input logic          mem_page
);
  localparam int unsigned OFS_W = $clog2(BLK_BYTES);

  AST_SAME_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) |-> mem_addr[AW-1:OFS_W] == $past(mem_addr[AW-1:OFS_W])); // R1

  AST_ZERO_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !busy && op_kind == 2'd0 |=> mem_req && mem_we); // R2

  AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rsp && mem_fault |=> done && !done_ok && !mem_req); // R3

  AST_FAIL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_ok |-> exc_addr == {$past(mem_addr[AW-1:OFS_W]), OFS_W'(0)}); // R4

  AST_PROBE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !busy && op_kind != 2'd0 |=> mem_req && !mem_we); // R5

  AST_PROBE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_addr[OFS_W-1:0] == '0); // R5

  AST_CODE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_ok && $past(mem_page) |-> exc_code == 4'd15); // R6

  AST_CODE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_ok && !$past(mem_page) |-> exc_code == 4'd7); // R6

  AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_ok |-> exc_code == 4'd0 && exc_addr == '0); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R7

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rsp |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R8

  AST_RSP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp |-> mem_ok != mem_fault); // R8
endmodule

bind cbo_seq cbo_seq_chk #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_cbo_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .op_valid  (op_valid),
  .op_kind   (op_kind),
  .busy      (busy),
  .done      (done),
  .done_ok   (done_ok),
  .exc_code  (exc_code),
  .exc_addr  (exc_addr),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_rsp   (mem_rsp),
  .mem_ok    (mem_ok),
  .mem_fault (mem_fault),
  .mem_page  (mem_page)
);

// File: tb/cbo_seq_bench.sv
`timescale 1ns/1ps
module cbo_seq_bench;
  localparam int AW  = 12;
  localparam int BLK = 8;
  localparam int MEMSZ = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_valid;
  logic [1:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic          busy, done, done_ok;
  logic [3:0]    exc_code;
  logic [AW-1:0] exc_addr;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          mem_rsp, mem_ok, mem_fault, mem_page;

  always #2.5 clk = ~clk;

  cbo_seq #(.AW(AW), .BLK_BYTES(BLK)) u_cbo_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .busy(busy), .done(done), .done_ok(done_ok),
    .exc_code(exc_code), .exc_addr(exc_addr), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp(mem_rsp), .mem_ok(mem_ok), .mem_fault(mem_fault),
    .mem_page(mem_page)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] mem_model [0:MEMSZ-1];

  // Responder configuration and observations.
  int lat = 0;
  bit flt_en = 0;
  int flt_addr = 0;
  bit flt_page = 0;
  int exp_base = 0;
  int wait_cnt = 0;
  int hold_addr = 0;
  bit hold_we = 0;
  int wr_cnt = 0, rd_cnt = 0, last_rd = 0;
  int order_err = 0, out_err = 0, stab_err = 0, data_err = 0;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 13 + 5) % 256) | 8'h01;
  endfunction

  task automatic chk(input bit cond, input string what, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // Memory responder.
  initial begin
    mem_rsp = 0; mem_ok = 0; mem_fault = 0; mem_page = 0;
    forever begin
      @(negedge clk);
      mem_rsp = 0; mem_ok = 0; mem_fault = 0; mem_page = 0;
      if (mem_req === 1'b1) begin
        if (wait_cnt == 0) begin
          hold_addr = int'(mem_addr);
          hold_we   = mem_we;
        end else if (int'(mem_addr) != hold_addr || mem_we != hold_we) begin
          stab_err++;
        end
        if (wait_cnt >= lat) begin
          wait_cnt = 0;
          mem_rsp = 1;
          if ((int'(mem_addr) / BLK) != (exp_base / BLK)) out_err++;
          if (flt_en && int'(mem_addr) == flt_addr) begin
            mem_fault = 1;
            mem_page  = flt_page;
          end else begin
            mem_ok = 1;
            if (mem_we) begin
              if (int'(mem_addr) != exp_base + wr_cnt) order_err++;
              if (mem_wdata != 8'h00) data_err++;
              mem_model[mem_addr] = mem_wdata;
              wr_cnt++;
            end else begin
              rd_cnt++;
              last_rd = int'(mem_addr);
            end
          end
        end else begin
          wait_cnt++;
        end
      end else begin
        wait_cnt = 0;
      end
    end
  end

  task automatic clear_obs();
    wr_cnt = 0; rd_cnt = 0; last_rd = -1;
    order_err = 0; out_err = 0; stab_err = 0; data_err = 0;
  endtask

  task automatic restore(input int base);
    for (int a = base - BLK; a < base + 2 * BLK; a++)
      if (a >= 0 && a < MEMSZ) mem_model[a] = pat(a);
  endtask

  task automatic run_op(input int kind, input int addr, input int lt,
                        input bit fen, input int fidx, input bit fpg);
    int base, stop, tmo, exp_code;
    bit exp_ok;
    base = addr - (addr % BLK);
    restore(base);
    clear_obs();
    exp_base = base; lat = lt; flt_en = fen; flt_addr = base + fidx; flt_page = fpg;
    exp_code = fpg ? 15 : 7;
    @(negedge clk);
    op_valid = 1; op_kind = 2'(kind); op_addr = AW'(addr);
    @(negedge clk);
    op_valid = 0;
    chk(busy === 1'b1, "R7 busy after accept", int'(busy), 1);
    tmo = 0;
    while (done !== 1'b1 && tmo < 200) begin
      @(negedge clk);
      tmo++;
    end
    chk(done === 1'b1, "R7 done seen", int'(done), 1);
    if (kind == 0) begin
      stop = fen ? fidx : BLK;
      exp_ok = !fen;
    end else begin
      stop = 0;
      exp_ok = !(fen && fidx == 0);
    end
    chk(done_ok == exp_ok, kind == 0 ? "R2 done_ok" : "R5 done_ok", int'(done_ok), int'(exp_ok));
    chk(int'(exc_code) == (exp_ok ? 0 : exp_code), "R6 exc_code", int'(exc_code), exp_ok ? 0 : exp_code);
    chk(int'(exc_addr) == (exp_ok ? 0 : base), "R4 exc_addr", int'(exc_addr), exp_ok ? 0 : base);
    chk(out_err == 0, "R1 request outside block", out_err, 0);
    chk(stab_err == 0, "R8 request changed while pending", stab_err, 0);
    if (kind == 0) begin
      chk(order_err == 0, "R2 write order", order_err, 0);
      chk(data_err == 0, "R2 write data", data_err, 0);
      chk(wr_cnt == stop, "R3 byte writes", wr_cnt, stop);
      for (int i = 0; i < BLK; i++) begin
        int e;
        e = (i < stop) ? 0 : int'(pat(base + i));
        chk(int'(mem_model[base + i]) == e, i < stop ? "R2 zeroed byte" : "R3 untouched byte",
            int'(mem_model[base + i]), e);
      end
    end else begin
      chk(wr_cnt == 0, "R5 no writes", wr_cnt, 0);
      chk(rd_cnt == (exp_ok ? 1 : 0), "R5 probe reads", rd_cnt, exp_ok ? 1 : 0);
      if (exp_ok) chk(last_rd == base, "R5 probe address", last_rd, base);
      for (int i = 0; i < BLK; i++)
        chk(mem_model[base + i] == pat(base + i), "R5 block unchanged",
            int'(mem_model[base + i]), int'(pat(base + i)));
    end
    if (base > 0)
      chk(mem_model[base - 1] == pat(base - 1), "R1 byte below block", int'(mem_model[base - 1]), int'(pat(base - 1)));
    if (base + BLK < MEMSZ)
      chk(mem_model[base + BLK] == pat(base + BLK), "R1 byte above block",
          int'(mem_model[base + BLK]), int'(pat(base + BLK)));
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R7 done single cycle then idle", int'({done, busy}), 0);
    flt_en = 0;
  endtask

  initial begin
    int bases [3];
    bases[0] = 0; bases[1] = 'h100; bases[2] = MEMSZ - BLK;
    for (int a = 0; a < MEMSZ; a++) mem_model[a] = pat(a);
    rst_n = 0; op_valid = 0; op_kind = 0; op_addr = 0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R9 reset state",
        int'({busy, done, mem_req}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R9 after release",
        int'({busy, done, mem_req}), 0);

    // Zero: every offset, positions, latencies, no fault and each fault byte.
    for (int b = 0; b < 3; b++)
      for (int off = 0; off < BLK; off++)
        for (int lt = 0; lt < 3; lt++) begin
          run_op(0, bases[b] + off, lt, 0, 0, 0);
          for (int f = 0; f < BLK; f++) begin
            run_op(0, bases[b] + off, lt, 1, f, 0);
            run_op(0, bases[b] + off, lt, 1, f, 1);
          end
        end

    // Probes: clean, flush, invalidate.
    for (int k = 1; k < 4; k++)
      for (int b = 0; b < 3; b++)
        for (int off = 0; off < BLK; off++)
          for (int lt = 0; lt < 3; lt++) begin
            run_op(k, bases[b] + off, lt, 0, 0, 0);
            run_op(k, bases[b] + off, lt, 1, 0, 0);
            run_op(k, bases[b] + off, lt, 1, 0, 1);
          end

    // R7: a request arriving while busy is dropped.
    restore('h200);
    restore('h400);
    clear_obs();
    exp_base = 'h200; lat = 1; flt_en = 0;
    @(negedge clk);
    op_valid = 1; op_kind = 2'd0; op_addr = AW'('h203);
    @(negedge clk);
    op_kind = 2'd1; op_addr = AW'('h400);
    @(negedge clk);
    op_valid = 0;
    begin
      int tmo;
      tmo = 0;
      while (done !== 1'b1 && tmo < 200) begin
        @(negedge clk);
        tmo++;
      end
    end
    repeat (6) @(negedge clk);
    chk(busy === 1'b0, "R7 idle after ignored request", int'(busy), 0);
    chk(rd_cnt == 0 && out_err == 0, "R7 no probe from ignored request", rd_cnt, 0);
    chk(wr_cnt == BLK, "R7 first operation completed", wr_cnt, BLK);

    finish_run();
  end
endmodule